// File: doc/BRIEF.md
# Boundary-Scan Test Access Controller

This block is the serial test port of a small device with four input pins and thirty-two output pins. It has a sixteen-state controller that follows TMS on each rising TCK edge. It also holds a 4-bit instruction register and three data registers: a one-bit bypass stage, a 32-bit identification word, and a boundary chain with one cell per pin. A tester drives TCK, TMS and TDI and reads TDO. Through these it can sample the live pin values, preload test values, and then take over the pads. It can also read the identification word or float every output.

The boundary chain mixes two kinds of cell. An input cell sits between a pin and the core. An output cell carries two values for its pad: the data and the enable. Each cell has a capture/shift flop and a separate update flop. When no test instruction is active, every pin passes straight through in both directions.

Top module: `bscan_tap`

## Requirements
- R1: While `porN` is low, and after any five consecutive rising TCK edges with TMS high, the controller is in Test-Logic-Reset. In that state the active instruction is IDCODE, the pads follow `coreOut`/`coreOe`, and `coreIn` follows `pinIn`.
- R2: State changes follow the standard sixteen-state TMS graph on the rising edge of TCK. This includes leaving Shift-DR through Exit1-DR into Pause-DR and returning through Exit2-DR without losing shifted bits.
- R3: Capture-IR loads the value 0001. The instruction register shifts least significant bit first. A new instruction takes effect on the rising edge that leaves Update-IR.
- R4: The opcodes are EXTEST 0000, SAMPLE/PRELOAD 0001, IDCODE 0010, HIGHZ 0011 and BYPASS 1111. Every other code behaves as BYPASS.
- R5: Under IDCODE, Capture-DR loads a 32-bit word whose bit 0 is 1 (default 0x1A5CE035). The word is shifted out least significant bit first.
- R6: The bypass register is one bit and captures 0. Under bypass, each TDI bit appears on TDO one shift later.
- R7: The boundary chain has 68 bits, and bit 0 is nearest TDO. Bit i (i < 4) is input cell i. Output cell k holds its data at bit 4+2k and its enable at bit 5+2k. Capture-DR loads `pinIn`, `coreOut` and `coreOe` into these positions.
- R8: Update-DR copies the boundary shift stages into the update stages only under SAMPLE/PRELOAD or EXTEST. Under SAMPLE/PRELOAD a preload leaves the pads and `coreIn` on their functional values.
- R9: Under EXTEST, `padOut`/`padOe` come from the output-cell update stages and `coreIn` comes from the input-cell update stages. Changes on `coreOut` then have no effect on the pads.
- R10: Under HIGHZ, every bit of `padOe` is 0, `padOut` follows `coreOut`, and the bypass register sits between TDI and TDO.
- R11: TDO changes only on the falling edge of TCK. `tdoOe` is 1 only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdoOe | output | 1 | Drive enable for TDO (1 only while shifting) |
| pinIn | input | 4 | Values arriving at the input pins |
| coreIn | output | 4 | Input values delivered to the core |
| coreOut | input | 32 | Core output data |
| coreOe | input | 32 | Core output enables |
| padOut | output | 32 | Data driven toward the output pads |
| padOe | output | 32 | Enables driven toward the output pads |

## Verification
Under EXTEST, the capture of live core values and the driving of the pads from the update stages happen together. Capture-DR reads `coreOut` while the pads are still held at the previous update values. The bench provokes this by first changing `coreOut` between two EXTEST scans. It then checks two things: the shifted-out image holds the new core values, and the pads keep the old preload until the Update-DR edge. A second overlap is a five-TMS-high escape from the middle of an EXTEST Shift-DR, which passes through Update-DR on its way to reset. The bench judges this by whether the pads return to functional values and the next scan reads the identification word.

// File: rtl/bscan_tap_pkg.sv
package bscan_tap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET   = 4'h0,
    ST_IDLE    = 4'h1,
    ST_SEL_DR  = 4'h2,
    ST_CAP_DR  = 4'h3,
    ST_SH_DR   = 4'h4,
    ST_EX1_DR  = 4'h5,
    ST_PAU_DR  = 4'h6,
    ST_EX2_DR  = 4'h7,
    ST_UPD_DR  = 4'h8,
    ST_SEL_IR  = 4'h9,
    ST_CAP_IR  = 4'hA,
    ST_SH_IR   = 4'hB,
    ST_EX1_IR  = 4'hC,
    ST_PAU_IR  = 4'hD,
    ST_EX2_IR  = 4'hE,
    ST_UPD_IR  = 4'hF
  } tapState_t;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0010;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0011;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  // Strobes from the controller to the register datapath.
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic shiftIr;
    logic irSerial;
    logic selBs;
    logic selId;
    logic extest;
    logic highz;
  } tapStrobes_t;

endpackage

// File: rtl/bscan_tap_ctrl.sv
module bscan_tap_ctrl
  import bscan_tap_pkg::*;
(
  input  logic        tck,
  input  logic        porN,
  input  logic        tms,
  input  logic        tdi,
  output tapStrobes_t stb
);

  tapState_t state, nextState;
  logic [IR_W-1:0] irShift, irReg, irActive;

  always_comb begin
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      default:   nextState = tms ? ST_SEL_DR : ST_IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      state   <= ST_RESET;
      irShift <= IR_CAPTURE;
      irReg   <= OP_IDCODE;
    end else begin
      state <= nextState;
      if (state == ST_RESET)       irReg   <= OP_IDCODE;
      else if (state == ST_UPD_IR) irReg   <= irShift;
      if (state == ST_CAP_IR)      irShift <= IR_CAPTURE;
      else if (state == ST_SH_IR)  irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  // Reset state forces IDCODE without waiting for a further edge.
  assign irActive = (state == ST_RESET) ? OP_IDCODE : irReg;

  always_comb begin
    stb           = '0;
    stb.captureDr = (state == ST_CAP_DR);
    stb.shiftDr   = (state == ST_SH_DR);
    stb.updateDr  = (state == ST_UPD_DR);
    stb.shiftIr   = (state == ST_SH_IR);
    stb.irSerial  = irShift[0];
    unique case (irActive)
      OP_EXTEST: begin stb.extest = 1'b1; stb.selBs = 1'b1; end
      OP_SAMPLE: stb.selBs = 1'b1;
      OP_IDCODE: stb.selId = 1'b1;
      OP_HIGHZ:  stb.highz = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/bscan_tap_dp.sv
module bscan_tap_dp
  import bscan_tap_pkg::*;
#(
  parameter int              NUM_IN  = 4,
  parameter int              NUM_OUT = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A5C_E035
) (
  input  logic               tck,
  input  logic               porN,
  input  logic               tdi,
  input  tapStrobes_t        stb,
  input  logic [NUM_IN-1:0]  pinIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_IN-1:0]  coreIn,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe,
  output logic               tdo,
  output logic               tdoOe
);

  localparam int CHAIN = NUM_IN + 2 * NUM_OUT;
  localparam logic [ID_W-1:0] ID_EFF = {ID_CODE[ID_W-1:1], 1'b1};

  logic [CHAIN-1:0] capVec, bsShift, bsUpd;
  logic [ID_W-1:0]  idShift;
  logic             bypassReg, drSerial;

  // Input cells first (nearest TDO), then data/enable pairs per output.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_inCell
    assign capVec[i] = pinIn[i];
    assign coreIn[i] = stb.extest ? bsUpd[i] : pinIn[i];
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_outCell
    localparam int D = NUM_IN + 2 * k;
    assign capVec[D]   = coreOut[k];
    assign capVec[D+1] = coreOe[k];
    assign padOut[k]   = stb.extest ? bsUpd[D] : coreOut[k];
    assign padOe[k]    = stb.highz ? 1'b0 : (stb.extest ? bsUpd[D+1] : coreOe[k]);
  end

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      bsShift   <= '0;
      bsUpd     <= '0;
      idShift   <= '0;
      bypassReg <= 1'b0;
    end else begin
      if (stb.captureDr) begin
        bypassReg <= 1'b0;
        if (stb.selBs) bsShift <= capVec;
        if (stb.selId) idShift <= ID_EFF;
      end else if (stb.shiftDr) begin
        bypassReg <= tdi;
        if (stb.selBs) bsShift <= {tdi, bsShift[CHAIN-1:1]};
        if (stb.selId) idShift <= {tdi, idShift[ID_W-1:1]};
      end
      if (stb.updateDr && stb.selBs) bsUpd <= bsShift;
    end
  end

  assign drSerial = stb.selBs ? bsShift[0] : (stb.selId ? idShift[0] : bypassReg);

  always_ff @(negedge tck or negedge porN) begin
    if (!porN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= stb.shiftIr ? stb.irSerial : drSerial;
      tdoOe <= stb.shiftIr | stb.shiftDr;
    end
  end

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_tap_pkg::*;
#(
  parameter int              NUM_IN  = 4,
  parameter int              NUM_OUT = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A5C_E035
) (
  input  logic               tck,
  input  logic               porN,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdoOe,
  input  logic [NUM_IN-1:0]  pinIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe
);

  tapStrobes_t stb;

  bscan_tap_ctrl u_ctrl (
    .tck  (tck),
    .porN (porN),
    .tms  (tms),
    .tdi  (tdi),
    .stb  (stb)
  );

  bscan_tap_dp #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .ID_CODE (ID_CODE)
  ) u_dp (
    .tck     (tck),
    .porN    (porN),
    .tdi     (tdi),
    .stb     (stb),
    .pinIn   (pinIn),
    .coreOut (coreOut),
    .coreOe  (coreOe),
    .coreIn  (coreIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .tdo     (tdo),
    .tdoOe   (tdoOe)
  );

endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
  import bscan_tap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 32
) (
  input logic               tck,
  input logic               porN,
  input logic               tms,
  input tapStrobes_t        stb,
  input logic [NUM_IN-1:0]  pinIn,
  input logic [NUM_IN-1:0]  coreIn,
  input logic [NUM_OUT-1:0] coreOut,
  input logic [NUM_OUT-1:0] padOut,
  input logic [NUM_OUT-1:0] padOe,
  input logic               tdoOe
);

  // R1: five TMS-high edges always land on an IDCODE selection
  a_r1_five_high_resets: assert property (@(posedge tck) disable iff (!porN)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
    |-> stb.selId);

  // R10: HIGHZ leaves no pad driven
  a_r10_highz_floats: assert property (@(posedge tck) disable iff (!porN)
    stb.highz |-> (padOe == '0));

  // R9: outside EXTEST the pad data is the core's
  a_r9_pads_functional: assert property (@(posedge tck) disable iff (!porN)
    !stb.extest |-> (padOut == coreOut));

  // R9: outside EXTEST the core sees the live pins
  a_r9_core_functional: assert property (@(posedge tck) disable iff (!porN)
    !stb.extest |-> (coreIn == pinIn));

  // R11: TDO driver off whenever no shift state is held
  a_r11_tdo_quiet: assert property (@(posedge tck) disable iff (!porN)
    !(stb.shiftDr || stb.shiftIr) |-> !tdoOe);

endmodule

bind bscan_tap bscan_tap_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .tck     (tck),
  .porN    (porN),
  .tms     (tms),
  .stb     (stb),
  .pinIn   (pinIn),
  .coreIn  (coreIn),
  .coreOut (coreOut),
  .padOut  (padOut),
  .padOe   (padOe),
  .tdoOe   (tdoOe)
);

// File: tb/bscan_tap_test.sv
module bscan_tap_test;

  localparam int PERIOD = 20;
  localparam int NI = 4;
  localparam int NO = 32;
  localparam int CH = NI + 2 * NO;
  localparam logic [31:0] ID_EXP = 32'h1A5C_E035;

  logic tck = 1'b0, porN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoOe;
  logic [NI-1:0] pinIn = '0, coreIn;
  logic [NO-1:0] coreOut = '0, coreOe = '0, padOut, padOe;

  int checks = 0, errors = 0;
  logic lastTdo, edgeTdo;
  logic [79:0] sdOut;

  // Stimulus table: {pinIn, coreOut, coreOe}
  localparam logic [67:0] TBL [4] = '{
    {4'hA, 32'hDEAD_BEEF, 32'h0F0F_F0F0},
    {4'h5, 32'h1234_5678, 32'hFFFF_0000},
    {4'hF, 32'h0000_0000, 32'hFFFF_FFFF},
    {4'h3, 32'hC3A5_5A3C, 32'h8000_0001}
  };

  bscan_tap uut (
    .tck(tck), .porN(porN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .pinIn(pinIn), .coreIn(coreIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe)
  );

  always #(PERIOD/2) tck = ~tck;

  function automatic logic [CH-1:0] packChain(logic [NI-1:0] p, logic [NO-1:0] o, logic [NO-1:0] e);
    logic [CH-1:0] v;
    for (int i = 0; i < NI; i++) v[i] = p[i];
    for (int k = 0; k < NO; k++) begin
      v[NI+2*k]   = o[k];
      v[NI+2*k+1] = e[k];
    end
    return v;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    lastTdo = tdo;
    tms = m;
    tdi = d;
    @(posedge tck); #1;
    edgeTdo = tdo;
    @(negedge tck); #1;
  endtask

  task automatic scanDr(input logic [79:0] din, input int len);
    sdOut = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < len; i++) begin
      if (i == 0) check(tdoOe === 1'b1, "R11 tdoOe in Shift-DR", 80'(tdoOe), 80'd1);
      tick(i == len - 1, din[i]);
      sdOut[i] = lastTdo;
      if (i == 0) check(edgeTdo === lastTdo, "R11 tdo held across rising edge", 80'(edgeTdo), 80'(lastTdo));
    end
    tick(1, 0); tick(0, 0);
    check(tdoOe === 1'b0, "R11 tdoOe off in Run-Test-Idle", 80'(tdoOe), 80'd0);
  endtask

  task automatic scanIr(input logic [3:0] op);
    sdOut = '0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i]);
      sdOut[i] = lastTdo;
    end
    tick(1, 0); tick(0, 0);
    check(sdOut[3:0] === 4'b0001, "R3 Capture-IR pattern", sdOut, 80'h1);
  endtask

  initial begin
    #(PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [CH-1:0] pre, img;
    logic [NO-1:0] expOut, expOe;
    logic [NI-1:0] expIn;
    pinIn = 4'h6; coreOut = 32'hA5A5_0F0F; coreOe = 32'h00FF_FF00;
    repeat (3) @(negedge tck);
    #1 porN = 1'b1;

    // R1 reset state
    check(tdoOe === 1'b0, "R1 tdoOe after reset", 80'(tdoOe), 80'd0);
    check(padOut === coreOut && padOe === coreOe, "R1 pads functional after reset", 80'(padOe), 80'(coreOe));
    check(coreIn === pinIn, "R1 coreIn functional after reset", 80'(coreIn), 80'(pinIn));
    tick(0, 0);

    // R5 IDCODE selected by default
    scanDr('0, 32);
    check(sdOut[31:0] === ID_EXP, "R5 IDCODE word", sdOut, 80'(ID_EXP));
    check(sdOut[0] === 1'b1, "R5 IDCODE bit0", 80'(sdOut[0]), 80'd1);

    // R7/R8 sample and preload across table
    scanIr(4'b0001);
    pre = '0;
    for (int t = 0; t < 4; t++) begin
      {pinIn, coreOut, coreOe} = TBL[t];
      #1;
      img = packChain(pinIn, coreOut, coreOe);
      pre = ~img;
      scanDr(80'(pre), CH);
      check(sdOut[CH-1:0] === img, "R7 boundary capture image", sdOut, 80'(img));
      check(padOut === coreOut && padOe === coreOe, "R8 preload leaves pads functional", 80'(padOut), 80'(coreOut));
      check(coreIn === pinIn, "R8 preload leaves coreIn functional", 80'(coreIn), 80'(pinIn));
    end

    // R9 EXTEST drives pads from the preloaded update stages
    scanIr(4'b0000);
    for (int k = 0; k < NO; k++) begin
      expOut[k] = pre[NI+2*k];
      expOe[k]  = pre[NI+2*k+1];
    end
    expIn = pre[NI-1:0];
    check(padOut === expOut, "R9 EXTEST padOut", 80'(padOut), 80'(expOut));
    check(padOe === expOe, "R9 EXTEST padOe", 80'(padOe), 80'(expOe));
    check(coreIn === expIn, "R9 EXTEST coreIn", 80'(coreIn), 80'(expIn));
    coreOut = ~coreOut;
    #1;
    check(padOut === expOut, "R9 coreOut change ignored by pads", 80'(padOut), 80'(expOut));
    // Capture of new core values while pads hold the old preload
    img = packChain(pinIn, coreOut, coreOe);
    pre = {CH{1'b0}} | 68'h5_5555_5555_AAAA_AAAA;
    scanDr(80'(pre), CH);
    check(sdOut[CH-1:0] === img, "R7 EXTEST capture of live core", sdOut, 80'(img));
    for (int k = 0; k < NO; k++) expOut[k] = pre[NI+2*k];
    check(padOut === expOut, "R9 EXTEST pads after new update", 80'(padOut), 80'(expOut));

    // R10 HIGHZ: pads float, bypass path
    scanIr(4'b0011);
    check(padOe === '0, "R10 HIGHZ padOe", 80'(padOe), 80'd0);
    check(padOut === coreOut, "R10 HIGHZ padOut functional", 80'(padOut), 80'(coreOut));
    scanDr(80'hB2, 8);
    check(sdOut[7:0] === 8'h64, "R10 HIGHZ one-bit path", sdOut, 80'h64);

    // R4 unused code acts as bypass
    scanIr(4'b0101);
    scanDr(80'hC9, 8);
    check(sdOut[7:0] === 8'h92, "R4 unused opcode bypass", sdOut, 80'h92);
    check(padOe === coreOe, "R4 unused opcode pads functional", 80'(padOe), 80'(coreOe));

    // R6 BYPASS opcode
    scanIr(4'b1111);
    scanDr(80'h3D, 8);
    check(sdOut[7:0] === 8'h7A, "R6 BYPASS one-bit delay", sdOut, 80'h7A);

    // R1 escape from mid-EXTEST shift with five TMS highs
    scanIr(4'b0000);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 1);
    check(padOut === coreOut && padOe === coreOe, "R1 TMS reset restores pads", 80'(padOe), 80'(coreOe));
    check(coreIn === pinIn, "R1 TMS reset restores coreIn", 80'(coreIn), 80'(pinIn));
    tick(0, 0);
    scanDr('0, 32);
    check(sdOut[31:0] === ID_EXP, "R1 IDCODE after TMS reset", sdOut, 80'(ID_EXP));

    // R2 pause in the middle of an IDCODE shift
    sdOut = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 16; i++) begin tick(i == 15, 0); sdOut[i] = lastTdo; end
    tick(0, 0); tick(0, 0);
    check(tdoOe === 1'b0, "R11 tdoOe off in Pause-DR", 80'(tdoOe), 80'd0);
    tick(1, 0); tick(0, 0);
    for (int i = 16; i < 32; i++) begin tick(i == 31, 0); sdOut[i] = lastTdo; end
    tick(1, 0); tick(0, 0);
    check(sdOut[31:0] === ID_EXP, "R2 pause and resume keeps shift", sdOut, 80'(ID_EXP));

    summary();
  end

endmodule